// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from the receive, transmit and buffer logic of a network controller and holds them as pending status bits. Software reads the pending bits over a small byte-wide register bus. It acknowledges a bit by writing a 1 to that bit's position. A mask register selects which pending bits may raise the level-sensitive interrupt line.

The unit also holds the run-control part of the command byte: the stop flag, the start flag and the three-bit remote transfer field. The stop and start commands drive the top status bit, which reports that the controller is held in reset. This bit cannot be acknowledged. It is set by a stop command and cleared when a start command arrives while the controller is not already started.

Two small state machines carry the control. The run-state machine has the states RUN_IDLE and RUN_ACTIVE. It takes the transition *launch* (RUN_IDLE to RUN_ACTIVE) on a command write with the start bit set, and the transition *halt* (RUN_ACTIVE to RUN_IDLE) on a command write with the start bit clear. The interrupt-line machine has the states IRQ_QUIET and IRQ_RAISED. It takes the transition *assert* when an enabled bit becomes pending and the transition *release* when no enabled bit remains pending. These conditions are evaluated on the next-cycle status and mask values, so they cover event pulses, acknowledge writes and mask writes.

Top module: `isr_unit`

## Requirements
- R1: An event pulse on `evt_in[i]` sets status bit i on the next clock edge. The bit stays set until it is acknowledged. Status bits in order from bit 0: packet received, packet sent, receive error, send error, ring overwrite, counter overflow, remote transfer done. The status register reads as {reset bit, status bits 6:0} with `reg_sel`=1.
- R2: A write with `reg_sel`=1 clears each status bit 0 to 6 whose written bit is 1. Bits written as 0 keep their value. Written bit 7 has no effect.
- R3: A write with `reg_sel`=2 loads mask bits 6:0. Reading with `reg_sel`=2 returns {0, mask 6:0}, so bit 7 always reads 0.
- R4: `irq` is high exactly when some status bit 0 to 6 is pending and its mask bit is set. It follows the edge at which an event, an acknowledge write or a mask write changes that condition.
- R5: A command write (`reg_sel`=0) with bit 0 set sets the reset status bit, unless R6 clears it in the same write. Command bit 0 reads back as the last written stop bit.
- R6: A command write with bit 1 set clears the reset status bit when the start flag was clear before the write. This takes priority over a stop in the same write. If the start flag was already set, the reset bit is left alone. Command bit 1 reads back as the start flag.
- R7: The remote transfer field, command bits 5:3, stores the written value. A written value of 0 is stored as 4. The command register reads back as {00, field, 0, start, stop}.
- R8: After hardware reset the command register reads 0x21, the status register reads 0x80, the mask reads 0x00 and `irq` is low.
- R9: When an event pulse and an acknowledge write for the same bit fall in the same cycle, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select: 0 command, 1 status, 2 mask, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| evt_in | input | 7 | Event pulses, one per status bit 0 to 6 |
| irq | output | 1 | Level interrupt request |

## Verification
The status bank is driven with single events, with two events at once and with acknowledge patterns that hit pending bits, miss pending bits, or touch only bit 7. This separates a clear-where-one write from a plain load, and a load that honours bit 7 from one that ignores it. Mask writes are made both while enabled bits are pending and while they are not, which shows whether the line is re-evaluated on mask writes and not only on events. A same-cycle event and acknowledge tests which of the two wins. The command sequences cover start from idle, start while already active, stop with and without start, and a zero transfer field. Together they tell apart the start-edge rule from a plain start level.

// File: rtl/isr_pkg.sv
package isr_pkg;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam int CMD_STOP_POS  = 0;
    localparam int CMD_START_POS = 1;
    localparam int CMD_XFER_LO   = 3;
    localparam int CMD_XFER_W    = 3;
    localparam logic [CMD_XFER_W-1:0] CMD_XFER_SAFE = 3'd4;

endpackage

// File: rtl/isr_cmd_ctl.sv
module isr_cmd_ctl
    import isr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic                  cmd_stop,
    input  logic                  cmd_start,
    input  logic [CMD_XFER_W-1:0] cmd_xfer,
    output logic                  stop_q,
    output logic                  start_q,
    output logic [CMD_XFER_W-1:0] xfer_q,
    output logic                  rst_flag_q
);

    run_state_e run_q;
    run_state_e run_d;
    logic       launch;
    logic       rst_flag_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= RUN_IDLE;
        else        run_q <= run_d;
    end

    // next state: launch / halt on command writes
    always_comb begin
        run_d = run_q;
        if (cmd_wr) begin
            unique case (run_q)
                RUN_IDLE:   run_d = cmd_start ? RUN_ACTIVE : RUN_IDLE;
                RUN_ACTIVE: run_d = cmd_start ? RUN_ACTIVE : RUN_IDLE;
                default:    run_d = RUN_IDLE;
            endcase
        end
    end

    // outputs derived from the run state
    always_comb begin
        start_q = (run_q == RUN_ACTIVE);
        launch  = cmd_wr && cmd_start && (run_q == RUN_IDLE);
    end

    // reset status bit: start edge overrides stop in the same write
    always_comb begin
        rst_flag_d = rst_flag_q;
        if (launch)
            rst_flag_d = 1'b0;
        else if (cmd_wr && cmd_stop)
            rst_flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q     <= 1'b1;
            xfer_q     <= CMD_XFER_SAFE;
            rst_flag_q <= 1'b1;
        end else begin
            rst_flag_q <= rst_flag_d;
            if (cmd_wr) begin
                stop_q <= cmd_stop;
                xfer_q <= (cmd_xfer == '0) ? CMD_XFER_SAFE : cmd_xfer;
            end
        end
    end

endmodule

// File: rtl/isr_status_bank.sv
module isr_status_bank #(
    parameter int N_SRC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_wr,
    input  logic [N_SRC-1:0] ack_bits,
    input  logic [N_SRC-1:0] evt,
    output logic [N_SRC-1:0] pend_q,
    output logic [N_SRC-1:0] pend_d
);

    // one identical set/clear cell per source; a new event beats an acknowledge
    for (genvar i = 0; i < N_SRC; i++) begin : g_cell
        assign pend_d[i] = evt[i] | (pend_q[i] & ~(ack_wr & ack_bits[i]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/isr_irq_ctl.sv
module isr_irq_ctl
    import isr_pkg::*;
#(
    parameter int N_SRC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic [N_SRC-1:0] pend_d,
    output logic [N_SRC-1:0] mask_q,
    output logic             irq
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic [N_SRC-1:0] mask_d;
    logic             hit;

    assign mask_d = mask_wr ? mask_wdata : mask_q;
    assign hit    = |(pend_d & mask_d);

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // next state: assert / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (hit)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!hit) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    // output process
    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/isr_unit.sv
module isr_unit
    import isr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-2:0] evt_in,
    output logic              irq
);

    localparam int N_SRC = DATA_W - 1;

    reg_sel_e              sel;
    logic                  wr_cmd, wr_stat, wr_mask;
    logic                  stop_q, start_q, rst_flag_q;
    logic [CMD_XFER_W-1:0] xfer_q;
    logic [N_SRC-1:0]      pend_q, pend_d, mask_q;
    logic                  unused_wbits;

    assign sel     = reg_sel_e'(reg_sel);
    assign wr_cmd  = reg_wr && (sel == SEL_CMD);
    assign wr_stat = reg_wr && (sel == SEL_STAT);
    assign wr_mask = reg_wr && (sel == SEL_MASK);
    assign unused_wbits = reg_wdata[DATA_W-1];

    isr_cmd_ctl u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (wr_cmd),
        .cmd_stop   (reg_wdata[CMD_STOP_POS]),
        .cmd_start  (reg_wdata[CMD_START_POS]),
        .cmd_xfer   (reg_wdata[CMD_XFER_LO +: CMD_XFER_W]),
        .stop_q     (stop_q),
        .start_q    (start_q),
        .xfer_q     (xfer_q),
        .rst_flag_q (rst_flag_q)
    );

    isr_status_bank #(.N_SRC(N_SRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_wr   (wr_stat),
        .ack_bits (reg_wdata[N_SRC-1:0]),
        .evt      (evt_in),
        .pend_q   (pend_q),
        .pend_d   (pend_d)
    );

    isr_irq_ctl #(.N_SRC(N_SRC)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (wr_mask),
        .mask_wdata (reg_wdata[N_SRC-1:0]),
        .pend_d     (pend_d),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CMD: begin
                reg_rdata[CMD_STOP_POS]                = stop_q;
                reg_rdata[CMD_START_POS]               = start_q;
                reg_rdata[CMD_XFER_LO +: CMD_XFER_W]   = xfer_q;
            end
            SEL_STAT: reg_rdata = {rst_flag_q, pend_q};
            SEL_MASK: reg_rdata = {1'b0, mask_q};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/isr_unit_chk.sv
module isr_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-2:0] evt_in,
    input logic              irq,
    input logic [DATA_W-2:0] pend_q,
    input logic [DATA_W-2:0] mask_q,
    input logic              rst_flag_q,
    input logic              start_q,
    input logic [2:0]        xfer_q
);

    p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((pend_q & $past(evt_in)) == $past(evt_in)));

    p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1) |=>
            ((pend_q & $past(reg_wdata[DATA_W-2:0] & ~evt_in)) == '0));

    p_ack_keeps_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1) |=> (rst_flag_q == $past(rst_flag_q)));

    p_mask_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd2) |-> (reg_rdata[DATA_W-1] == 1'b0));

    p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(pend_q & mask_q));

    p_stop_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && reg_wdata[0] && !(reg_wdata[1] && !start_q))
            |=> rst_flag_q);

    p_launch_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && reg_wdata[1] && !start_q) |=> !rst_flag_q);

    p_xfer_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_q != 3'd0);

    p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1 && ((evt_in & reg_wdata[DATA_W-2:0]) != '0))
            |=> ((pend_q & $past(evt_in & reg_wdata[DATA_W-2:0]))
                 == $past(evt_in & reg_wdata[DATA_W-2:0])));

endmodule

bind isr_unit isr_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .evt_in     (evt_in),
    .irq        (irq),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .rst_flag_q (rst_flag_q),
    .start_q    (start_q),
    .xfer_q     (xfer_q)
);

// File: tb/sim_isr_unit.sv
module sim_isr_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [6:0] evt_in = 7'h00;
    logic       irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        logic [1:0] sel;
        logic [7:0] rd;
        logic       irq;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    isr_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in),
        .irq       (irq)
    );

    // monitor: compares queued expectations shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (reg_rdata !== it.rd || irq !== it.irq) begin
                    errors++;
                    $display("FAIL %s: sel=%0d rdata=%02h irq=%b, expected rdata=%02h irq=%b",
                             it.tag, it.sel, reg_rdata, irq, it.rd, it.irq);
                end
            end
        end
    end

    task automatic look(input logic [1:0] sel, input logic [7:0] rd,
                        input logic exp_irq, input string tag);
        item_t it;
        @(negedge clk);
        reg_sel = sel;
        it.sel = sel; it.rd = rd; it.irq = exp_irq; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        #5;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ev(input logic [6:0] m);
        @(negedge clk);
        evt_in = m;
        @(negedge clk);
        evt_in = 7'h00;
    endtask

    task automatic wr_ev(input logic [1:0] sel, input logic [7:0] d, input logic [6:0] m);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; evt_in = m;
        @(negedge clk);
        reg_wr = 1'b0; evt_in = 7'h00;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        hw_reset();
        look(2'd0, 8'h21, 1'b0, "R8 command after reset");
        look(2'd1, 8'h80, 1'b0, "R8 status after reset");
        look(2'd2, 8'h00, 1'b0, "R8 mask after reset");

        ev(7'h01);
        look(2'd1, 8'h81, 1'b0, "R1 event sets bit0, R4 masked stays low");
        wr(2'd2, 8'hFF);
        look(2'd2, 8'h7F, 1'b1, "R3 mask bit7 reads 0, R4 mask write raises irq");
        ev(7'h44);
        look(2'd1, 8'hC5, 1'b1, "R1 two events together");
        wr(2'd1, 8'h80);
        look(2'd1, 8'hC5, 1'b1, "R2 bit7-only ack has no effect");
        wr(2'd1, 8'h04);
        look(2'd1, 8'hC1, 1'b1, "R2 ack clears only written ones");
        wr(2'd2, 8'h02);
        look(2'd2, 8'h02, 1'b0, "R4 mask write drops irq when nothing enabled");
        wr(2'd1, 8'h41);
        look(2'd1, 8'h80, 1'b0, "R2 ack clears bits 0 and 6");
        ev(7'h02);
        look(2'd1, 8'h82, 1'b1, "R4 enabled event raises irq");
        wr(2'd1, 8'h02);
        look(2'd1, 8'h80, 1'b0, "R4 ack releases irq");
        wr_ev(2'd1, 8'h02, 7'h02);
        look(2'd1, 8'h82, 1'b1, "R9 event beats same-cycle ack");
        wr(2'd1, 8'h02);
        look(2'd1, 8'h80, 1'b0, "R2 later ack clears it");

        wr(2'd0, 8'h22);
        look(2'd1, 8'h00, 1'b0, "R6 start from idle clears reset bit");
        look(2'd0, 8'h22, 1'b0, "R5 stop reads back 0, R6 start reads 1");
        wr(2'd0, 8'h23);
        look(2'd1, 8'h80, 1'b0, "R5 stop sets reset bit while active");
        look(2'd0, 8'h23, 1'b0, "R5 command readback with stop");
        wr(2'd0, 8'h22);
        look(2'd1, 8'h80, 1'b0, "R6 start while active leaves reset bit");
        wr(2'd0, 8'h02);
        look(2'd0, 8'h22, 1'b0, "R7 zero transfer field becomes 4");
        wr(2'd0, 8'h0A);
        look(2'd0, 8'h0A, 1'b0, "R7 nonzero field kept");
        wr(2'd0, 8'h08);
        look(2'd0, 8'h08, 1'b0, "R6 start flag cleared");
        wr(2'd0, 8'h0B);
        look(2'd1, 8'h00, 1'b0, "R6 start edge beats stop in same write");
        look(2'd0, 8'h0B, 1'b0, "R5 stop and start read back");

        ev(7'h02);
        look(2'd1, 8'h02, 1'b1, "R1 event before reset");
        hw_reset();
        look(2'd0, 8'h21, 1'b0, "R8 command after second reset");
        look(2'd1, 8'h80, 1'b0, "R8 status after second reset");
        look(2'd2, 8'h00, 1'b0, "R8 mask after second reset");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule